// File: doc/BRIEF.md
# Dual-Line Interrupt Controller with Ring Log

This block gathers event strobes from the command-response bus terminal logic. It turns them into two active-low interrupt lines for a host. One line serves hardware-class events and the other serves message-class events. Each event strobe carries three things: a set of type bits, a per-command enable mask for the message types, and a 16-bit source descriptor address.

The block masks each event in two steps. The host-writable enable register applies to every type bit. The per-command mask applies to the message bits only. Surviving bits accumulate in a pending register. A single mode input selects one of two behaviours for both lines together:
- In pulse mode, a line drops for a fixed number of clock cycles.
- In level mode, a line stays low until the host clears it. The host clears one line with its own acknowledge input, or clears both lines by reading the pending register.

Every event that survives masking also produces a two-word record in a 32-word ring in shared memory, written through a plain write port. The first word holds the event bits and the second holds the source address. The ring therefore keeps the sixteen most recent records and overwrites the oldest.

Top module: `irq_log_ctrl`

## Requirements
- R1: The enable register reads back zero after reset. After a write strobe it reads back the written value in the next cycle.
- R2: The type bits are encoded as follows:
  - bit 0: word count zero
  - bit 1: write address
  - bit 2: broadcast
  - bit 3: illegal command
  - bit 4: message error
  - bits 7:5: hardware events

  A message bit survives only if both its enable bit and its per-command mask bit are set. A hardware bit survives if its enable bit is set. Surviving bits are OR-ed into the pending register.
- R3: A pending read returns the current pending value and clears the register at the next edge. Bits of an event in the same cycle are kept.
- R4: In level mode, a line falls in the cycle after an event whose surviving bits include its class. It stays low until it is cleared.
- R5: In level mode, an acknowledge input clears only its own line. An event for that line in the same cycle wins over the acknowledge.
- R6: In level mode, a pending read clears both lines. A same-cycle event re-asserts its line.
- R7: In pulse mode, a line is low for exactly PULSE_CYC cycles after the event, and a new event restarts the count. Acknowledge inputs have no effect in pulse mode.
- R8: A record consists of two writes, made in the first and second cycles after the event:
  - The first write goes to LOG_BASE plus an even offset and carries the surviving bits, zero-extended.
  - The second write goes to the next address and carries the source address.
- R9: The record offset advances by two per record and wraps after 16 records. Addresses stay inside 0x0040 to 0x005F.
- R10: An event with no surviving bits changes no line, no pending bit and writes nothing.
- R11: Reset leaves pending at zero, both lines high, no write in progress and the log offset at zero.
- R12: Events arriving every second cycle each yield a complete record. Events must not arrive in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_level | input | 1 | 1 = level mode, 0 = pulse mode |
| evt_valid | input | 1 | Single-cycle event strobe |
| evt_bits | input | 8 | Event type bits |
| evt_cmd_en | input | 5 | Per-command message enables |
| evt_src | input | 16 | Source descriptor address |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write value |
| en_rdata | output | 8 | Enable register value |
| pend_rd | input | 1 | Pending register read strobe |
| pend_rdata | output | 8 | Pending register value |
| ack_hw | input | 1 | Hardware line acknowledge |
| ack_msg | input | 1 | Message line acknowledge |
| irq_hw_n | output | 1 | Hardware interrupt, active low |
| irq_msg_n | output | 1 | Message interrupt, active low |
| mem_we | output | 1 | Log write strobe |
| mem_addr | output | 16 | Log write address |
| mem_wdata | output | 16 | Log write data |

## Verification
An event strobe that sets a line can land in the same cycle as a clear of that line. The clear may come from the line's acknowledge input or from a pending read. In both cases the set must win, and a pending read must keep only the new event's bits. The bench drives these coincidences on purpose. It also lets them occur at random with acknowledges and reads mixed under events. A cycle-level model predicts every line, the pending value and each log write.

// File: rtl/irq_log_pkg.sv
// Shared constants and types for the interrupt controller.
package irq_log_pkg;
    localparam int MSG_N  = 5;   // message-class event types
    localparam int WORD_W = 16;  // shared memory word width
    // Record writer phases
    typedef enum logic [1:0] {WR_IDLE, WR_ID, WR_SRC} wr_state_e;
endpackage

// File: rtl/irq_pin_drv.sv
// One active-low interrupt line.
// Level mode: latches low on set; cleared by ack or by a pending read.
// Pulse mode: low for PULSE_CYC cycles after set; ack is ignored.
// Assumes set, ack and rd_clr are single-cycle strobes.
module irq_pin_drv #(
    parameter int PULSE_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_mode,
    input  logic set,
    input  logic ack,
    input  logic rd_clr,
    output logic irq_n
);
    localparam int CNT_W = $clog2(PULSE_CYC + 1);

    logic             lvl_q;
    logic [CNT_W-1:0] cnt_q;

    // Level latch: set wins over either clear source
    always_ff @(posedge clk) begin
        if (!rst_n)                        lvl_q <= 1'b0;
        else if (set && level_mode)        lvl_q <= 1'b1;
        else if ((level_mode && ack) || rd_clr) lvl_q <= 1'b0;
    end

    // Pulse counter: reload on set, count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (set && !level_mode)       cnt_q <= CNT_W'(PULSE_CYC);
        else if (cnt_q != '0)              cnt_q <= cnt_q - 1'b1;
    end

    // Output select by mode
    always_comb irq_n = level_mode ? ~lvl_q : (cnt_q == '0);
endmodule

// File: rtl/irq_log_writer.sv
// Writes a two-word record (event bits, source address) into a ring
// of LOG_WORDS words starting at LOG_BASE. LOG_WORDS is a power of two.
// Assumes a new record arrives no sooner than two cycles after the last.
module irq_log_writer
    import irq_log_pkg::*;
#(
    parameter int                 EV_W      = 8,
    parameter logic [WORD_W-1:0]  LOG_BASE  = 16'h0040,
    parameter int                 LOG_WORDS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_valid,
    input  logic [EV_W-1:0]   rec_id,
    input  logic [WORD_W-1:0] rec_src,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata
);
    localparam int IDX_W = $clog2(LOG_WORDS);

    wr_state_e         st_q;
    logic [IDX_W-1:0]  idx_q;
    logic [EV_W-1:0]   id_q;
    logic [WORD_W-1:0] src_q;

    // Phase sequencing and ring offset advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= WR_IDLE;
            idx_q <= '0;
            id_q  <= '0;
            src_q <= '0;
        end else begin
            case (st_q)
                WR_IDLE: if (rec_valid) begin
                    id_q  <= rec_id;
                    src_q <= rec_src;
                    st_q  <= WR_ID;
                end
                WR_ID:   st_q <= WR_SRC;
                WR_SRC: begin
                    idx_q <= idx_q + IDX_W'(2);
                    if (rec_valid) begin
                        id_q  <= rec_id;
                        src_q <= rec_src;
                        st_q  <= WR_ID;
                    end else begin
                        st_q  <= WR_IDLE;
                    end
                end
                default: st_q <= WR_IDLE;
            endcase
        end
    end

    // Memory port drive
    always_comb begin
        mem_we    = (st_q != WR_IDLE);
        mem_addr  = LOG_BASE + WORD_W'(idx_q) + ((st_q == WR_SRC) ? 16'd1 : 16'd0);
        mem_wdata = (st_q == WR_SRC) ? src_q : WORD_W'(id_q);
    end
endmodule

// File: rtl/irq_log_ctrl.sv
// Top: masks events, keeps the pending register, drives the hardware and
// message interrupt lines and feeds the ring log writer.
// Event bits [MSG_N-1:0] are message types, the rest are hardware types.
module irq_log_ctrl
    import irq_log_pkg::*;
#(
    parameter int                HW_N      = 3,
    parameter int                PULSE_CYC = 25,
    parameter logic [WORD_W-1:0] LOG_BASE  = 16'h0040,
    parameter int                LOG_WORDS = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_level,
    input  logic                      evt_valid,
    input  logic [MSG_N+HW_N-1:0]     evt_bits,
    input  logic [MSG_N-1:0]          evt_cmd_en,
    input  logic [WORD_W-1:0]         evt_src,
    input  logic                      en_wr,
    input  logic [MSG_N+HW_N-1:0]     en_wdata,
    output logic [MSG_N+HW_N-1:0]     en_rdata,
    input  logic                      pend_rd,
    output logic [MSG_N+HW_N-1:0]     pend_rdata,
    input  logic                      ack_hw,
    input  logic                      ack_msg,
    output logic                      irq_hw_n,
    output logic                      irq_msg_n,
    output logic                      mem_we,
    output logic [WORD_W-1:0]         mem_addr,
    output logic [WORD_W-1:0]         mem_wdata
);
    localparam int EV_W = MSG_N + HW_N;

    logic [EV_W-1:0] en_q;
    logic [EV_W-1:0] pend_q;
    logic [EV_W-1:0] eff;
    logic [1:0]      line_set;
    logic [1:0]      line_ack;
    logic [1:0]      line_irq_n;

    // Two-stage masking of the incoming event
    always_comb begin
        eff         = evt_valid ? (evt_bits & en_q & {{HW_N{1'b1}}, evt_cmd_en}) : '0;
        line_set[0] = |eff[EV_W-1:MSG_N];
        line_set[1] = |eff[MSG_N-1:0];
        line_ack[0] = ack_hw;
        line_ack[1] = ack_msg;
    end

    // Enable register
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= en_wdata;
    end

    // Pending register: read clears, new bits always land
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_rd ? '0 : pend_q) | eff;
    end

    // Line drivers: index 0 hardware, index 1 message
    for (genvar g = 0; g < 2; g++) begin : g_line
        irq_pin_drv #(.PULSE_CYC(PULSE_CYC)) u_drv (
            .clk        (clk),
            .rst_n      (rst_n),
            .level_mode (cfg_level),
            .set        (line_set[g]),
            .ack        (line_ack[g]),
            .rd_clr     (pend_rd),
            .irq_n      (line_irq_n[g])
        );
    end

    irq_log_writer #(
        .EV_W      (EV_W),
        .LOG_BASE  (LOG_BASE),
        .LOG_WORDS (LOG_WORDS)
    ) u_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .rec_valid (|eff),
        .rec_id    (eff),
        .rec_src   (evt_src),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    always_comb begin
        en_rdata   = en_q;
        pend_rdata = pend_q;
        irq_hw_n   = line_irq_n[0];
        irq_msg_n  = line_irq_n[1];
    end
endmodule

// File: rtl/irq_log_chk.sv
// Property checker for irq_log_ctrl, attached by bind.
module irq_log_chk
    import irq_log_pkg::*;
#(
    parameter int                HW_N      = 3,
    parameter logic [WORD_W-1:0] LOG_BASE  = 16'h0040,
    parameter int                LOG_WORDS = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_level,
    input logic                  evt_valid,
    input logic                  pend_rd,
    input logic [MSG_N+HW_N-1:0] pend_rdata,
    input logic                  ack_hw,
    input logic                  irq_hw_n,
    input logic                  irq_msg_n,
    input logic                  mem_we,
    input logic [WORD_W-1:0]     mem_addr
);
    logic [WORD_W-1:0] off;
    always_comb off = mem_addr - LOG_BASE;

    AST_EVT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> !evt_valid); // R12
    AST_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_rd && !evt_valid) |=> (pend_rdata == '0)); // R3
    AST_RD_CLR_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_level && pend_rd && !evt_valid) |=> (!cfg_level || (irq_hw_n && irq_msg_n))); // R6
    AST_ACK_HW: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_level && ack_hw && !evt_valid) |=> (!cfg_level || irq_hw_n)); // R5
    AST_LOG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr >= LOG_BASE && mem_addr < LOG_BASE + WORD_W'(LOG_WORDS))); // R9
    AST_LOG_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !off[0]) |=> (mem_we && mem_addr == $past(mem_addr) + 16'd1)); // R8
endmodule

bind irq_log_ctrl irq_log_chk #(
    .HW_N(HW_N), .LOG_BASE(LOG_BASE), .LOG_WORDS(LOG_WORDS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .evt_valid(evt_valid),
    .pend_rd(pend_rd), .pend_rdata(pend_rdata), .ack_hw(ack_hw),
    .irq_hw_n(irq_hw_n), .irq_msg_n(irq_msg_n), .mem_we(mem_we),
    .mem_addr(mem_addr)
);

// File: tb/sim_irq_log_ctrl.sv
// Bench: directed corner cases plus seeded random traffic, checked
// against a cycle model written from the requirements.
module sim_irq_log_ctrl;
    localparam int PULSE = 25;
    localparam int LOGW  = 32;
    localparam logic [15:0] BASE = 16'h0040;

    logic clk = 1'b0;
    logic rst_n, cfg_level, evt_valid, en_wr, pend_rd, ack_hw, ack_msg;
    logic [7:0]  evt_bits, en_wdata, en_rdata, pend_rdata;
    logic [4:0]  evt_cmd_en;
    logic [15:0] evt_src, mem_addr, mem_wdata;
    logic irq_hw_n, irq_msg_n, mem_we;

    int n_chk = 0;
    int n_err = 0;

    // model state
    logic [7:0]  m_en, m_pend, m_wid;
    logic [15:0] m_wsrc;
    logic [1:0]  m_lvl;
    int          m_cnt [2];
    int          m_wst, m_idx;

    always #5 clk = ~clk;

    irq_log_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .evt_valid(evt_valid),
        .evt_bits(evt_bits), .evt_cmd_en(evt_cmd_en), .evt_src(evt_src),
        .en_wr(en_wr), .en_wdata(en_wdata), .en_rdata(en_rdata),
        .pend_rd(pend_rd), .pend_rdata(pend_rdata), .ack_hw(ack_hw),
        .ack_msg(ack_msg), .irq_hw_n(irq_hw_n), .irq_msg_n(irq_msg_n),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] eff_of(input logic v, input logic [7:0] b,
                                          input logic [7:0] en, input logic [4:0] c);
        return v ? (b & en & {3'b111, c}) : 8'h00;
    endfunction

    function automatic logic exp_line(input int i);
        return cfg_level ? ~m_lvl[i] : (m_cnt[i] == 0);
    endfunction

    task automatic idle_in();
        evt_valid = 0; evt_bits = 0; evt_cmd_en = 0; evt_src = 0;
        en_wr = 0; en_wdata = 0; pend_rd = 0; ack_hw = 0; ack_msg = 0;
    endtask

    // Advance one clock, update the model, compare all outputs
    task automatic step();
        logic [7:0] e;
        logic [1:0] s, a;
        e = eff_of(evt_valid, evt_bits, m_en, evt_cmd_en);
        s = {|e[4:0], |e[7:5]};
        a = {ack_msg, ack_hw};
        for (int i = 0; i < 2; i++) begin
            if (s[i] && cfg_level) m_lvl[i] = 1'b1;
            else if ((cfg_level && a[i]) || pend_rd) m_lvl[i] = 1'b0;
            if (s[i] && !cfg_level) m_cnt[i] = PULSE;
            else if (m_cnt[i] != 0) m_cnt[i]--;
        end
        m_pend = (pend_rd ? 8'h00 : m_pend) | e;
        if (en_wr) m_en = en_wdata;
        case (m_wst)
            0: if (e != 0) begin m_wid = e; m_wsrc = evt_src; m_wst = 1; end
            1: m_wst = 2;
            default: begin
                m_idx = (m_idx + 2) % LOGW;
                if (e != 0) begin m_wid = e; m_wsrc = evt_src; m_wst = 1; end
                else m_wst = 0;
            end
        endcase
        @(posedge clk); #1;
        chk("R1", en_rdata, m_en);
        chk("R2", pend_rdata, m_pend);
        chk(cfg_level ? "R4 hw" : "R7 hw", irq_hw_n, exp_line(0));
        chk(cfg_level ? "R4 msg" : "R7 msg", irq_msg_n, exp_line(1));
        chk("R8 we", mem_we, m_wst != 0);
        if (m_wst != 0) begin
            chk("R9 addr", mem_addr, BASE + m_idx + (m_wst == 2 ? 1 : 0));
            chk("R8 data", mem_wdata, m_wst == 2 ? m_wsrc : {8'h00, m_wid});
        end
    endtask

    task automatic do_reset();
        idle_in();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        m_en = 0; m_pend = 0; m_lvl = 0; m_cnt[0] = 0; m_cnt[1] = 0;
        m_wst = 0; m_idx = 0; m_wid = 0; m_wsrc = 0;
        chk("R11 pend", pend_rdata, 0);
        chk("R11 hw", irq_hw_n, 1);
        chk("R11 msg", irq_msg_n, 1);
        chk("R11 we", mem_we, 0);
        rst_n = 1;
    endtask

    task automatic set_en(input logic [7:0] v);
        en_wr = 1; en_wdata = v; step(); en_wr = 0;
    endtask

    task automatic fire(input logic [7:0] b, input logic [4:0] c, input logic [15:0] src);
        evt_valid = 1; evt_bits = b; evt_cmd_en = c; evt_src = src;
        step();
        evt_valid = 0; evt_bits = 0; evt_cmd_en = 0;
    endtask

    // Watchdog
    initial begin
        #2_000_000;
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int cnt;
        int seen_we;
        logic prev_evt;
        void'($urandom(32'd4711));
        cfg_level = 1;
        do_reset();

        // R1: enable register write/read
        set_en(8'hFF);
        chk("R1", en_rdata, 8'hFF);

        // R4: hardware event drops the hardware line only
        fire(8'h20, 5'h00, 16'hABCD);
        chk("R4", irq_hw_n, 0);
        chk("R4", irq_msg_n, 1);
        step(); step();
        // R5: message ack leaves hardware line low
        ack_msg = 1; step(); ack_msg = 0;
        chk("R5", irq_hw_n, 0);
        // R5: ack and event together, set wins
        ack_hw = 1; fire(8'h40, 5'h00, 16'h0011); ack_hw = 0;
        chk("R5 set wins", irq_hw_n, 0);
        step(); step();
        ack_hw = 1; step(); ack_hw = 0;
        chk("R5 cleared", irq_hw_n, 1);

        // R2: message bit needs the per-command mask
        fire(8'h01, 5'h01, 16'h1234);
        chk("R2", irq_msg_n, 0);
        step(); step();
        // R3/R6: pending read with coincident event
        pend_rd = 1; fire(8'h04, 5'h04, 16'h2222); pend_rd = 0;
        chk("R3 keep new", pend_rdata, 8'h04);
        chk("R6 set wins", irq_msg_n, 0);
        step(); step();
        pend_rd = 1; step(); pend_rd = 0;
        chk("R3 cleared", pend_rdata, 0);
        chk("R6 hw", irq_hw_n, 1);
        chk("R6 msg", irq_msg_n, 1);

        // R10: nothing survives masking
        seen_we = 0;
        fire(8'h1F, 5'h00, 16'h5555);
        for (int i = 0; i < 3; i++) begin seen_we |= mem_we; step(); end
        chk("R10 we", seen_we, 0);
        chk("R10 line", irq_msg_n, 1);
        chk("R10 pend", pend_rdata, 0);

        // R7: pulse length, acks ignored
        cfg_level = 0;
        fire(8'h80, 5'h00, 16'h0707);
        cnt = 0;
        while (!irq_hw_n && cnt < 100) begin
            cnt++; ack_hw = 1; step();
        end
        ack_hw = 0;
        chk("R7 width", cnt, PULSE);

        // R9/R12: 17 records at minimum spacing, wrap to base
        cfg_level = 1;
        do_reset();
        set_en(8'hFF);
        for (int i = 0; i < 17; i++) begin
            fire(8'h02, 5'h1F, 16'(i + 16'h100));
            chk("R9 id addr", mem_addr, BASE + 2 * (i % 16));
            step();
            chk("R12 src", mem_wdata, i + 16'h100);
        end
        step(); step();

        // Seeded random traffic
        prev_evt = 0;
        for (int t = 0; t < 4000; t++) begin
            idle_in();
            if (t % 700 == 0) cfg_level = ~cfg_level;
            if (!prev_evt && ($urandom % 3 == 0)) begin
                evt_valid  = 1;
                evt_bits   = 8'($urandom);
                evt_cmd_en = 5'($urandom);
                evt_src    = 16'($urandom);
            end
            ack_hw  = ($urandom % 6 == 0);
            ack_msg = ($urandom % 6 == 0);
            pend_rd = ($urandom % 8 == 0);
            if ($urandom % 50 == 0) begin en_wr = 1; en_wdata = 8'($urandom); end
            prev_evt = evt_valid;
            step();
        end
        idle_in();
        step();

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule